// File: doc/BRIEF.md
# MAC Address Hash Table Engine

This engine inserts and removes 48-bit destination MAC addresses in a 2048-slot address table that lives in an external single-port RAM. Each request computes an 11-bit slot index from the address, packs the address into a 64-bit entry with three control flags, and walks the table linearly from that index until it reaches a free slot or an entry holding the same address. The walk is bounded by a hop limit and wraps from the last slot back to slot 0.

After reset the engine first writes zero to every slot, so the table starts with no valid entry. It then accepts one request at a time through a valid/ready pair and signals completion with a one-cycle `done` pulse. `full` pulses together with `done` when an insertion finds no usable slot within the hop limit. The receive-side filtering lookup is handled elsewhere. It reads the same table using the entry layout defined here.

Top module: `mac_hash_engine`

## Requirements
- R1: After reset, `req_ready` stays low while the engine writes zero to all 2048 slots, one slot per cycle. `req_ready` rises only after exactly 2048 writes.
- R2: The address is taken as bytes B0..B5, with B0 on `req_mac[47:40]`. Each byte is bit-reversed. H is {rev(B0), rev(B1)} and L is {rev(B2), rev(B3), rev(B4), rev(B5)}. The slot index is {L[3:2], {L[14:8],L[1:0]} ^ L[23:15] ^ {H[0],L[31:24]}}.
- R3: An entry is 64 bits, with the low word in bits [31:0] and the high word in bits [63:32]. Using M = `req_mac`, the low word is {M[20], M[19:16], M[31:28], M[27:24], M[39:36], M[35:32], M[47:44], M[43:40], rd, skip, valid}, with valid in bit 0. The high word is {13'b0, M[7:4], M[3:0], M[15:12], M[11:8], M[23:21]}. Every write is either such an entry with valid set or all zeros.
- R4: An add whose hashed slot is free writes the entry there, with exactly one RAM write. `done` is high for exactly one cycle.
- R5: An occupied, non-matching slot sends the probe to the next index. The index after 0x7FF is 0x000.
- R6: The probe stops at the first slot that is either free or valid with equal words outside bits [2:0]. An add overwrites the slot where the probe stopped, which also updates skip and rd.
- R7: An add that meets HOPS occupied, non-matching slots (default 12) writes nothing. It raises `full` in the same cycle as `done`.
- R8: A delete that stops on a matching entry writes zero to both words of that slot.
- R9: A delete that stops on a free slot, or that exhausts the hop limit, writes nothing and leaves `full` low.
- R10: A request is accepted only when `req_ready` is high. `req_valid` while busy is ignored. The RAM is idle while the engine is ready.
- R11: A request reads at most HOPS slots, one per probe, at consecutive indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Engine idle, request accepted on this cycle if valid |
| req_mac | input | 48 | MAC address, first byte in [47:40] |
| req_del | input | 1 | 1 = delete, 0 = add |
| req_skip | input | 1 | Skip flag stored in the entry |
| req_rd | input | 1 | Discard flag stored in the entry |
| done | output | 1 | One-cycle completion pulse |
| full | output | 1 | Add failed within the hop limit, pulses with done |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 11 | RAM slot index |
| ram_wdata | output | 64 | RAM write data {high word, low word} |
| ram_rdata | input | 64 | RAM read data, valid one cycle after a read |

## Verification
The assertions assume that the RAM returns read data exactly one cycle after a read, and that no other agent writes the table while a request is in flight. The bench models a RAM with that latency and is its only user. The step and bound properties count reads from the accept edge, so they also rely on `req_mac` and the flags being stable in the accept cycle. The bench drives them one cycle ahead and pulses `req_valid` while the engine is busy only to show that such a pulse is dropped.

// File: rtl/mac_hash_engine.sv
`timescale 1ns/1ps
module mac_hash_engine #(
  parameter int HOPS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [47:0] req_mac,
  input  logic        req_del,
  input  logic        req_skip,
  input  logic        req_rd,
  output logic        done,
  output logic        full,
  output logic        ram_en,
  output logic        ram_we,
  output logic [10:0] ram_addr,
  output logic [63:0] ram_wdata,
  input  logic [63:0] ram_rdata
);
  localparam int IDX_W = 11;
  localparam int HOP_W = $clog2(HOPS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;
  localparam logic [HOP_W-1:0] LAST_HOP = HOP_W'(HOPS - 1);

  typedef enum logic [2:0] {ST_CLR, ST_IDLE, ST_RD, ST_CHK, ST_WR} state_t;
  state_t state;

  function automatic logic [7:0] rev8(input logic [7:0] x);
    for (int i = 0; i < 8; i++) rev8[i] = x[7-i];
  endfunction

  logic [15:0] hw;
  logic [31:0] lw;
  logic [8:0]  fold;
  logic [IDX_W-1:0] hash;
  logic [15:0] mh;
  logic [31:0] ml;
  logic [31:0] new_lo;
  logic [31:0] new_hi;

  assign hw   = {rev8(req_mac[47:40]), rev8(req_mac[39:32])};
  assign lw   = {rev8(req_mac[31:24]), rev8(req_mac[23:16]), rev8(req_mac[15:8]), rev8(req_mac[7:0])};
  assign fold = {lw[14:8], lw[1:0]} ^ lw[23:15] ^ {hw[0], lw[31:24]};
  assign hash = {lw[3:2], fold};

  assign mh = req_mac[47:32];
  assign ml = req_mac[31:0];
  assign new_lo = {ml[20], ml[19:16], ml[31:28], ml[27:24],
                   mh[7:4], mh[3:0], mh[15:12], mh[11:8], 3'b000};
  assign new_hi = {13'd0, ml[7:4], ml[3:0], ml[15:12], ml[11:8], ml[23:21]};

  logic [IDX_W-1:0] clr_idx;
  logic [IDX_W-1:0] idx;
  logic [HOP_W-1:0] hop;
  logic [28:0]      key_lo;
  logic [31:0]      key_hi;
  logic             key_skip, key_rd, del_q;

  logic slot_free, slot_match, stop_here;
  assign slot_free  = !ram_rdata[0];
  assign slot_match = ram_rdata[0] && ((ram_rdata | 64'h7) == {key_hi, key_lo, 3'b111});
  assign stop_here  = slot_free || slot_match;

  assign req_ready = (state == ST_IDLE);
  assign ram_en    = (state == ST_CLR) || (state == ST_RD) || (state == ST_WR);
  assign ram_we    = (state == ST_CLR) || (state == ST_WR);
  assign ram_addr  = (state == ST_CLR) ? clr_idx : idx;
  assign ram_wdata = ((state == ST_CLR) || del_q) ? 64'd0
                   : {key_hi, key_lo, key_rd, key_skip, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CLR;
      clr_idx  <= '0;
      idx      <= '0;
      hop      <= '0;
      key_lo   <= '0;
      key_hi   <= '0;
      key_skip <= 1'b0;
      key_rd   <= 1'b0;
      del_q    <= 1'b0;
      done     <= 1'b0;
      full     <= 1'b0;
    end else begin
      done <= 1'b0;
      full <= 1'b0;
      case (state)
        ST_CLR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == LAST_IDX) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            idx      <= hash;
            hop      <= '0;
            key_lo   <= new_lo[31:3];
            key_hi   <= new_hi;
            key_skip <= req_skip;
            key_rd   <= req_rd;
            del_q    <= req_del;
            state    <= ST_RD;
          end
        end
        ST_RD: state <= ST_CHK;
        ST_CHK: begin
          if (stop_here) begin
            if (!del_q || slot_match) begin
              state <= ST_WR;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end else if (hop == LAST_HOP) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            full  <= !del_q;
          end else begin
            hop   <= hop + 1'b1;
            idx   <= idx + 1'b1;
            state <= ST_RD;
          end
        end
        ST_WR: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [IDX_W-1:0] last_rd;
  logic [HOP_W-1:0] rd_seen;
  logic             rd_issue;
  assign rd_issue = ram_en && !ram_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd <= '0;
      rd_seen <= '0;
    end else begin
      if (req_valid && req_ready) rd_seen <= '0;
      else if (rd_issue) rd_seen <= rd_seen + 1'b1;
      if (rd_issue) last_rd <= ram_addr;
    end
  end

  p_full_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> done);
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ram_en);
  p_write_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wdata[0] || ram_wdata == 64'd0));
  p_probe_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && rd_seen != '0) |-> ram_addr == last_rd + 1'b1);
  p_hop_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> rd_seen < HOP_W'(HOPS));
endmodule

// File: tb/tb_mac_hash_engine.sv
`timescale 1ns/1ps
module tb_mac_hash_engine;
  localparam int PERIOD = 10;
  localparam int HOPS = 12;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [47:0] req_mac = '0;
  logic req_del = 1'b0, req_skip = 1'b0, req_rd = 1'b0;
  logic req_ready, done, full, ram_en, ram_we;
  logic [10:0] ram_addr;
  logic [63:0] ram_wdata;
  logic [63:0] ram_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt, rd_cnt;
  logic [63:0] mem [2048];

  always #(PERIOD/2) clk = ~clk;

  mac_hash_engine #(.HOPS(HOPS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mac(req_mac), .req_del(req_del), .req_skip(req_skip), .req_rd(req_rd),
    .done(done), .full(full), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] <= {32'hDEADBEEF, 32'hFFFF_FFF1};
      wr_cnt <= 0;
      rd_cnt <= 0;
      ram_rdata <= '0;
    end else if (ram_en) begin
      if (ram_we) begin
        mem[ram_addr] <= ram_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        ram_rdata <= mem[ram_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  // vector: {del, skip, rd, nowrite, idx[10:0], mac[47:0]}
  localparam logic [62:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 11'h7BA, 48'h0200_1234_5678},
    {1'b0, 1'b1, 1'b0, 1'b0, 11'h7BB, 48'h0400_1234_5678},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'h7BC, 48'h0600_1234_5678},
    {1'b0, 1'b0, 1'b1, 1'b0, 11'h7BB, 48'h0400_1234_5678},
    {1'b1, 1'b0, 1'b0, 1'b0, 11'h7BA, 48'h0200_1234_5678},
    {1'b0, 1'b1, 1'b1, 1'b0, 11'h7BA, 48'h0600_1234_5678},
    {1'b1, 1'b0, 1'b0, 1'b1, 11'h000, 48'h0800_1234_5678},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'h6BA, 48'h0280_1234_5678},
    {1'b0, 1'b0, 1'b1, 1'b0, 11'h7FF, 48'h1000_0000_FEF0},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'h000, 48'h1200_0000_FEF0},
    {1'b1, 1'b0, 1'b0, 1'b0, 11'h000, 48'h1200_0000_FEF0}
  };

  function automatic string vtag(input int i);
    case (i)
      0: vtag = "R4";  1: vtag = "R5";  2: vtag = "R5";  3: vtag = "R6";
      4: vtag = "R8";  5: vtag = "R6";  6: vtag = "R9";  7: vtag = "R2";
      8: vtag = "R2";  9: vtag = "R5";  default: vtag = "R8";
    endcase
  endfunction

  function automatic logic [63:0] pack(input logic [47:0] m, input logic s, input logic r);
    logic [31:0] lo, hi;
    lo = {m[20], m[19:16], m[31:28], m[27:24], m[39:36], m[35:32], m[47:44], m[43:40], r, s, 1'b1};
    hi = {13'd0, m[7:4], m[3:0], m[15:12], m[11:8], m[23:21]};
    return {hi, lo};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [47:0] m, input logic d, input logic s, input logic r,
                      output logic fl, output int nw, output int nr);
    int w0, r0, lim;
    lim = 0;
    while (!req_ready && lim < 3000) begin @(negedge clk); lim++; end
    w0 = wr_cnt; r0 = rd_cnt;
    req_mac = m; req_del = d; req_skip = s; req_rd = r; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lim = 0;
    while (!done && lim < 200) begin @(negedge clk); lim++; end
    chk("R4 done seen", {63'd0, done}, 64'd1);
    fl = full;
    nw = wr_cnt - w0;
    nr = rd_cnt - r0;
    @(negedge clk);
    chk("R4 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic fl;
    int nw, nr, nz, lim;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {63'd0, req_ready}, 64'd0);
    chk("R4 reset done/full", {62'd0, done, full}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready low during clear", {63'd0, req_ready}, 64'd0);
    lim = 0;
    while (!req_ready && lim < 3000) begin @(negedge clk); lim++; end
    chk("R1 clear write count", 64'(wr_cnt), 64'd2048);
    nz = 0;
    for (int i = 0; i < 2048; i++) if (mem[i] != 64'd0) nz++;
    chk("R1 table all zero", 64'(nz), 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [47:0] m;
      logic [10:0] ix;
      m = VEC[v][47:0];
      ix = VEC[v][58:48];
      send(m, VEC[v][62], VEC[v][61], VEC[v][60], fl, nw, nr);
      chk({vtag(v), " no full"}, {63'd0, fl}, 64'd0);
      if (VEC[v][59]) begin
        chk({vtag(v), " no write"}, 64'(nw), 64'd0);
      end else begin
        chk({vtag(v), " one write"}, 64'(nw), 64'd1);
        chk({vtag(v), " slot content"}, mem[ix],
            VEC[v][62] ? 64'd0 : pack(m, VEC[v][61], VEC[v][60]));
      end
      if (v == 6) chk("R11 miss reads", 64'(nr), 64'd4);
    end

    // R10: a pulse while busy is dropped
    begin
      int w0;
      w0 = wr_cnt;
      req_mac = 48'h2000_1234_5678; req_del = 1'b0; req_skip = 1'b0; req_rd = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_mac = 48'h1400_0000_FEF0;
      @(negedge clk);
      chk("R10 busy ready low", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      lim = 0;
      while (!done && lim < 200) begin @(negedge clk); lim++; end
      repeat (6) @(negedge clk);
      chk("R10 single write", 64'(wr_cnt - w0), 64'd1);
      chk("R10 accepted slot", mem[11'h7BD], pack(48'h2000_1234_5678, 1'b0, 1'b0));
      chk("R10 dropped slot", mem[11'h000], 64'd0);
    end

    // R7 / R9 / R8 on a chain filled to the hop limit
    for (int k = 1; k <= HOPS; k++) begin
      logic [47:0] m;
      m = {8'(k), 8'h00, 32'hA0B0_C0D0};
      send(m, 1'b0, 1'b0, 1'b1, fl, nw, nr);
      chk("R5 chain slot", mem[11'h410 + 11'(k - 1)], pack(m, 1'b0, 1'b1));
    end
    send({8'(HOPS + 1), 8'h00, 32'hA0B0_C0D0}, 1'b0, 1'b0, 1'b0, fl, nw, nr);
    chk("R7 full raised", {63'd0, fl}, 64'd1);
    chk("R7 no write", 64'(nw), 64'd0);
    chk("R11 reads at limit", 64'(nr), 64'(HOPS));
    send({8'(HOPS + 2), 8'h00, 32'hA0B0_C0D0}, 1'b1, 1'b0, 0, fl, nw, nr);
    chk("R9 delete miss no full", {63'd0, fl}, 64'd0);
    chk("R9 delete miss no write", 64'(nw), 64'd0);
    send({8'(HOPS), 8'h00, 32'hA0B0_C0D0}, 1'b1, 1'b0, 1'b0, fl, nw, nr);
    chk("R8 delete at last hop", mem[11'h410 + 11'(HOPS - 1)], 64'd0);
    chk("R8 one write", 64'(nw), 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule